// File: doc/BRIEF.md
# VCO Sub-Band Calibration Engine

This block picks one of 256 sub-bands of a wide-range oscillator before the phase-locked loop is closed. It uses a binary search. Each trial band is applied to the oscillator. The engine waits a few reference cycles for the frequency to settle, then counts oscillator edges directly over a window of sixteen reference cycles. It compares that count with a target taken from the programmed division ratio. The target includes the integer part and the top four fraction bits, so fractional settings land on the right sub-band instead of on the one nearest the integer ratio.

Oscillator edges are counted in the oscillator clock domain by a free-running Gray-coded counter. The count is brought into the reference domain through a two-stage synchronizer. The engine takes a snapshot of the count at the start and at the end of each window and subtracts the two. A one-cycle start strobe launches a calibration. A one-cycle done pulse ends it, and the final band code is then held until the next start.

Top module: `vco_band_cal`

## Requirements
- R1: While reset is asserted, and until the first start, `band_code` is 0 and `cal_done` is 0.
- R2: A calibration tries the band bits from bit 7 down to bit 0. For each bit it counts oscillator rising edges over 16 reference cycles. The bit is cleared if the count is greater than the target and kept otherwise. The result is the largest band whose count does not exceed the target, provided the count rises with the band code.
- R3: The target equals `div_int`*16 + `div_frac[22:19]`. Fraction bits 18:0 have no effect on the result.
- R4: If the target is above the count of every band, the result is 255. If it is below the count of band 0, the result is 0.
- R5: Let the start be sampled at reference edge E. `cal_done` is then high for exactly one cycle, the cycle after edge E+160, and is low from E+1 until that edge.
- R6: After `cal_done`, `band_code` keeps the result until the next start.
- R7: A start strobe that arrives during a calibration is ignored. The run is not restarted and its target does not change.
- R8: The ratio inputs are captured at the start edge. Changing them during a calibration has no effect on that calibration.
- R9: In the cycle after the start edge, `band_code` is 8'h80, the first trial value.
- R10: Between two consecutive oscillator edges, the oscillator-domain count that is handed to the reference domain changes by at most one bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| vco_clk | input | 1 | Oscillator clock, counted directly |
| cal_start | input | 1 | One-cycle start strobe, reference domain |
| div_int | input | 8 | Integer part of the division ratio |
| div_frac | input | 23 | Fractional part of the division ratio; only the top 4 bits are used |
| band_code | output | 8 | Trial band during a search, final band afterwards |
| cal_done | output | 1 | One-cycle pulse when the last bit is resolved |

## Verification
Every result has a fixed cycle offset from the edge at which the start is sampled. The first trial code is due one cycle after that edge. The done pulse and final code are due after edge E+160, since there are 8 steps of 4 settle cycles plus 16 window cycles. `cal_done` must fall again one cycle later. The bench drives inputs and samples outputs on falling edges and counts rising edges from E. It checks that done stays low on each of the 159 intermediate cycles, and checks the code and the pulse exactly at edge 160 and 161. Mid-run disturbances, a second start or a changed ratio, are applied at a chosen cycle offset inside the same counted loop.

// File: rtl/vco_band_cal_pkg.sv
`timescale 1ns/1fs
package vco_band_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETTLE  = 2'd1,
    ST_MEASURE = 2'd2
  } cal_state_e;
endpackage

// File: rtl/cal_rst_sync.sv
`timescale 1ns/1fs
module cal_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/cal_gray_counter.sv
`timescale 1ns/1fs
module cal_gray_counter #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] gray_o
);
  logic [CNT_W-1:0] bin_q, bin_d;
  logic [CNT_W-1:0] gray_q, gray_d;

  always_comb begin
    bin_d  = bin_q + CNT_W'(1);
    gray_d = bin_q ^ (bin_q >> 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bin_q  <= '0;
      gray_q <= '0;
    end else begin
      bin_q  <= bin_d;
      gray_q <= gray_d;
    end
  end

  assign gray_o = gray_q;

  // R10: the value crossing into the reference domain moves one bit at a time
  assert_gray_one_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gray_q ^ $past(gray_q)) <= 1);
endmodule

// File: rtl/cal_gray_sync.sv
`timescale 1ns/1fs
module cal_gray_sync #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] gray_i,
  output logic [CNT_W-1:0] bin_o
);
  logic [CNT_W-1:0] s1_q, s2_q;
  logic [CNT_W-1:0] bin;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    bin[CNT_W-1] = s2_q[CNT_W-1];
    for (int i = CNT_W - 2; i >= 0; i--) begin
      bin[i] = bin[i+1] ^ s2_q[i];
    end
  end

  assign bin_o = bin;
endmodule

// File: rtl/cal_search_fsm.sv
`timescale 1ns/1fs
module cal_search_fsm
  import vco_band_cal_pkg::*;
#(
  parameter int BAND_W     = 8,
  parameter int INT_W      = 8,
  parameter int FRAC_KEEP  = 4,
  parameter int CNT_W      = 14,
  parameter int SETTLE_CYC = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [INT_W-1:0]     int_i,
  input  logic [FRAC_KEEP-1:0] frac_i,
  input  logic [CNT_W-1:0]     cnt_i,
  output logic [BAND_W-1:0]    band_o,
  output logic                 done_o
);
  localparam int WIN_CYC = 1 << FRAC_KEEP;
  localparam int TGT_W   = INT_W + FRAC_KEEP;
  localparam int TMR_MAX = (WIN_CYC > SETTLE_CYC) ? WIN_CYC : SETTLE_CYC;
  localparam int TMR_W   = $clog2(TMR_MAX) + 1;
  localparam int BIT_W   = (BAND_W > 1) ? $clog2(BAND_W) : 1;

  cal_state_e        state_q, state_d;
  logic [TMR_W-1:0]  tmr_q, tmr_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BAND_W-1:0] band_q, band_d;
  logic [TGT_W-1:0]  tgt_q, tgt_d;
  logic [CNT_W-1:0]  snap_q, snap_d;
  logic              done_q, done_d;

  logic [CNT_W-1:0]  win_cnt;
  logic              too_high;
  logic [BIT_W-1:0]  bit_dn;

  assign win_cnt  = cnt_i - snap_q;
  assign too_high = win_cnt > CNT_W'(tgt_q);
  assign bit_dn   = bit_q - BIT_W'(1);

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    bit_d   = bit_q;
    band_d  = band_q;
    tgt_d   = tgt_q;
    snap_d  = snap_q;
    done_d  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d = ST_SETTLE;
          tmr_d   = TMR_W'(SETTLE_CYC - 1);
          bit_d   = BIT_W'(BAND_W - 1);
          band_d  = '0;
          band_d[BAND_W-1] = 1'b1;
          tgt_d   = {int_i, frac_i};
        end
      end
      ST_SETTLE: begin
        if (tmr_q == '0) begin
          state_d = ST_MEASURE;
          tmr_d   = TMR_W'(WIN_CYC - 1);
          snap_d  = cnt_i;
        end else begin
          tmr_d = tmr_q - TMR_W'(1);
        end
      end
      ST_MEASURE: begin
        if (tmr_q == '0) begin
          if (too_high) band_d[bit_q] = 1'b0;
          if (bit_q == '0) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            band_d[bit_dn] = 1'b1;
            bit_d   = bit_dn;
            state_d = ST_SETTLE;
            tmr_d   = TMR_W'(SETTLE_CYC - 1);
          end
        end else begin
          tmr_d = tmr_q - TMR_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      bit_q   <= '0;
      band_q  <= '0;
      tgt_q   <= '0;
      snap_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      bit_q   <= bit_d;
      band_q  <= band_d;
      tgt_q   <= tgt_d;
      snap_q  <= snap_d;
      done_q  <= done_d;
    end
  end

  assign band_o = band_q;
  assign done_o = done_q;

  logic [BAND_W-1:0] low_mask;
  assign low_mask = (BAND_W'(1) << bit_q) - BAND_W'(1);

  // R5: the completion flag never lasts two cycles
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R6: with no calibration running and no start, the code stays put
  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start_i) |=> $stable(band_q));
  // R7: a start while busy leaves the captured target alone
  assert_busy_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && start_i) |=> $stable(tgt_q));
  // R2: bits below the one under trial are still clear during a search
  assert_lower_bits_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE) |-> ((band_q & low_mask) == '0));
endmodule

// File: rtl/vco_band_cal.sv
`timescale 1ns/1fs
module vco_band_cal #(
  parameter int BAND_W     = 8,
  parameter int INT_W      = 8,
  parameter int FRAC_W     = 23,
  parameter int FRAC_KEEP  = 4,
  parameter int CNT_W      = 14,
  parameter int SETTLE_CYC = 4
) (
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              vco_clk,
  input  logic              cal_start,
  input  logic [INT_W-1:0]  div_int,
  input  logic [FRAC_W-1:0] div_frac,
  output logic [BAND_W-1:0] band_code,
  output logic              cal_done
);
  logic             ref_rst_n;
  logic             vco_rst_n;
  logic [CNT_W-1:0] vco_gray;
  logic [CNT_W-1:0] ref_cnt;
  logic             frac_low_unused;

  assign frac_low_unused = ^div_frac[FRAC_W-FRAC_KEEP-1:0];

  cal_rst_sync u_ref_rst (.clk(ref_clk), .arst_n(rst_n), .srst_n(ref_rst_n));
  cal_rst_sync u_vco_rst (.clk(vco_clk), .arst_n(rst_n), .srst_n(vco_rst_n));

  cal_gray_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(vco_clk), .rst_n(vco_rst_n), .gray_o(vco_gray)
  );

  cal_gray_sync #(.CNT_W(CNT_W)) u_sync (
    .clk(ref_clk), .rst_n(ref_rst_n), .gray_i(vco_gray), .bin_o(ref_cnt)
  );

  cal_search_fsm #(
    .BAND_W(BAND_W), .INT_W(INT_W), .FRAC_KEEP(FRAC_KEEP),
    .CNT_W(CNT_W), .SETTLE_CYC(SETTLE_CYC)
  ) u_fsm (
    .clk(ref_clk), .rst_n(ref_rst_n), .start_i(cal_start),
    .int_i(div_int), .frac_i(div_frac[FRAC_W-1 -: FRAC_KEEP]),
    .cnt_i(ref_cnt), .band_o(band_code), .done_o(cal_done)
  );
endmodule

// File: tb/vco_band_cal_tb_top.sv
`timescale 1ns/1fs
module vco_band_cal_tb_top;
  logic        ref_clk;
  logic        rst_n;
  logic        vco_clk;
  logic        cal_start;
  logic [7:0]  div_int;
  logic [22:0] div_frac;
  logic [7:0]  band_code;
  logic        cal_done;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  vco_band_cal dut_i (
    .ref_clk(ref_clk), .rst_n(rst_n), .vco_clk(vco_clk), .cal_start(cal_start),
    .div_int(div_int), .div_frac(div_frac), .band_code(band_code), .cal_done(cal_done)
  );

  // 50 MHz reference
  initial begin
    ref_clk = 1'b0;
    forever #10 ref_clk = ~ref_clk;
  end

  // Oscillator model: f = fref * (20 + band/4), so a 16-cycle window counts 320 + 4*band
  function automatic real vco_half();
    real b;
    b = $isunknown(band_code) ? 0.0 : real'(band_code);
    return 10.0 / (20.0 + b / 4.0);
  endfunction

  initial begin
    vco_clk = 1'b0;
    forever begin
      #(vco_half());
      vco_clk = ~vco_clk;
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge ref_clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic [22:0] frac_of(input [3:0] nib, input [18:0] low);
    return {nib, low};
  endfunction

  // One calibration; optionally disturbs inputs at cycle mid_at after the start edge
  task automatic run_cal(input [7:0] n, input [22:0] fr, input int mid_at,
                         input bit mid_start, input [7:0] mn, input [22:0] mf,
                         input [7:0] exp_band, input string req);
    @(negedge ref_clk);
    div_int   = n;
    div_frac  = fr;
    cal_start = 1'b1;
    @(negedge ref_clk);            // start sampled at edge E
    cal_start = 1'b0;
    chk(band_code == 8'h80, "R9 first trial", band_code, 8'h80);
    for (int i = 1; i < 160; i++) begin
      if (i == mid_at) begin
        div_int   = mn;
        div_frac  = mf;
        cal_start = mid_start;
      end else begin
        cal_start = 1'b0;
      end
      @(negedge ref_clk);          // after edge E+i
      if (cal_done) chk(1'b0, "R5 early done", i, 160);
    end
    cal_start = 1'b0;
    @(negedge ref_clk);            // after edge E+160
    chk(cal_done == 1'b1, "R5 done at 160", cal_done, 1);
    chk(band_code == exp_band, req, band_code, exp_band);
    @(negedge ref_clk);
    chk(cal_done == 1'b0, "R5 done one cycle", cal_done, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cal_start = 1'b0;
    div_int = 8'd0;
    div_frac = '0;
    repeat (3) @(negedge ref_clk);
    chk(band_code == 8'd0, "R1 band in reset", band_code, 0);
    chk(cal_done == 1'b0, "R1 done in reset", cal_done, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge ref_clk);
    chk(band_code == 8'd0, "R1 band after reset", band_code, 0);
    chk(cal_done == 1'b0, "R1 done after reset", cal_done, 0);
  endtask

  task automatic t_search();
    // target 50*16+10 = 810 -> largest b with 320+4b <= 810 is 122
    run_cal(8'd50, frac_of(4'd10, 19'd0), 0, 1'b0, 8'd0, '0, 8'd122, "R2 mid search");
    // target 83*16+6 = 1334 -> 253
    run_cal(8'd83, frac_of(4'd6, 19'd0), 0, 1'b0, 8'd0, '0, 8'd253, "R2 high search");
  endtask

  task automatic t_fraction();
    run_cal(8'd40, frac_of(4'd6, 19'd0), 0, 1'b0, 8'd0, '0, 8'd81, "R3 nibble 6");
    run_cal(8'd40, frac_of(4'd14, 19'd0), 0, 1'b0, 8'd0, '0, 8'd83, "R3 nibble 14");
    run_cal(8'd40, frac_of(4'd6, 19'h7FFFF), 0, 1'b0, 8'd0, '0, 8'd81, "R3 low bits ignored");
  endtask

  task automatic t_extremes();
    run_cal(8'd90, frac_of(4'd0, 19'd0), 0, 1'b0, 8'd0, '0, 8'd255, "R4 top band");
    run_cal(8'd19, frac_of(4'd0, 19'd0), 0, 1'b0, 8'd0, '0, 8'd0, "R4 bottom band");
  endtask

  task automatic t_hold();
    run_cal(8'd20, frac_of(4'd2, 19'd0), 0, 1'b0, 8'd0, '0, 8'd0, "R2 lowest fit");
    run_cal(8'd50, frac_of(4'd10, 19'd0), 0, 1'b0, 8'd0, '0, 8'd122, "R2 repeat");
    div_int = 8'd20;
    repeat (40) @(negedge ref_clk);
    chk(band_code == 8'd122, "R6 held after done", band_code, 122);
    chk(cal_done == 1'b0, "R6 no further done", cal_done, 0);
  endtask

  task automatic t_busy_start();
    run_cal(8'd50, frac_of(4'd10, 19'd0), 50, 1'b1, 8'd20, frac_of(4'd2, 19'd0),
            8'd122, "R7 start while busy");
  endtask

  task automatic t_ratio_change();
    run_cal(8'd83, frac_of(4'd6, 19'd0), 30, 1'b0, 8'd40, frac_of(4'd6, 19'd0),
            8'd253, "R8 ratio change mid run");
  endtask

  initial begin
    t_reset();
    t_search();
    t_fraction();
    t_extremes();
    t_hold();
    t_busy_start();
    t_ratio_change();
    finish_run();
  end
endmodule